// File: doc/BRIEF.md
# Parallel Port Frame Sync Controller

This block moves one data word of up to 16 bits per port clock between a parallel pin bus and a word stream on the system side. It serves converter front ends and video links that mark lines and frames with sync pulses. The port runs as a receiver or a transmitter. Its syncs are either generated on chip from a line length and a line count, or taken from a rising edge on an input pin.

Each sync opens a transfer window. The window's first word falls a set number of port clocks after the sync, and the window then lasts for a set number of consecutive words. A small state machine walks each window through three states: WIN_IDLE (waiting for a sync), WIN_WAIT (counting the delay) and WIN_MOVE (moving the remaining words). The transitions are:
- start-with-wait: WIN_IDLE to WIN_WAIT on a sync when the delay is non-zero.
- start-moving: WIN_IDLE to WIN_MOVE on a sync with zero delay and more than one word.
- delay-done: WIN_WAIT to WIN_MOVE when the delay count is reached and more than one word is set.
- short-window: WIN_WAIT to WIN_IDLE when the delay count is reached and one word is set.
- window-done: WIN_MOVE to WIN_IDLE after the last word.
- disable: any state to WIN_IDLE when the enable bit is low.

On the system side, received words are held in a one-word register with a valid/ready handshake. Words to send are taken with a ready strobe. A missed handshake gives a one-cycle overrun or underrun pulse.

Top module: `ppfs_ctrl`

## Requirements
- R1: While `cfg_en` is low: both sync outputs are low, `tx_ready` and `pd_oe` are low, and `rx_valid` drops at the next edge. The line and window counters restart, so the first enabled cycle is position zero.
- R2: With internal syncs (`cfg_ext`=0), `sync1_out` is high for one cycle in the first enabled cycle and then once every `cfg_line_len` cycles.
- R3: With `cfg_two_sync`=1 and internal syncs, `sync2_out` is high together with `sync1_out` on line zero, once every `cfg_lines` lines. With `cfg_two_sync`=0 it stays low.
- R4: With external syncs (`cfg_ext`=1), a cycle where `sync1_in` is 1 after being 0 in the previous cycle starts a window. Syncs that arrive while a window is open are ignored, and both sync outputs stay low.
- R5: A window started in cycle t moves words in cycles t+`cfg_delay` up to t+`cfg_delay`+`cfg_words`-1. A delay of 0 moves the first word in cycle t. A word count of 0 moves nothing.
- R6: In receive mode (`cfg_tx`=0), `pd_in` sampled in a transfer cycle appears on `rx_data` with `rx_valid` high from the next cycle. The word is held until a cycle with `rx_ready` high.
- R7: In receive mode, a transfer cycle where a held word is not being taken gives a one-cycle `overrun` pulse in the next cycle. The new word is dropped and the held word is kept.
- R8: In transmit mode (`cfg_tx`=1), `tx_ready` is high exactly in transfer cycles, and a word offered with `tx_valid` drives `pd_out` from the next cycle. `pd_oe` is high while enabled in transmit mode.
- R9: In transmit mode, a transfer cycle with `tx_valid` low gives a one-cycle `underrun` pulse in the next cycle, and `pd_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Port enable; low restarts all counters |
| cfg_tx | input | 1 | 1 transmit, 0 receive |
| cfg_ext | input | 1 | 1 sync from `sync1_in`, 0 internally generated |
| cfg_two_sync | input | 1 | Enables the second (frame) sync level |
| cfg_line_len | input | 16 | Cycles between line syncs (at least 1) |
| cfg_lines | input | 16 | Lines per frame (at least 1) |
| cfg_delay | input | 16 | Cycles from sync to first word |
| cfg_words | input | 16 | Words per window |
| sync1_in | input | 1 | External line sync |
| sync1_out | output | 1 | Generated line sync |
| sync2_out | output | 1 | Generated frame sync |
| pd_in | input | 16 | Parallel data from pins |
| pd_out | output | 16 | Parallel data to pins |
| pd_oe | output | 1 | Output enable for `pd_out` |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | Received word is held |
| rx_ready | input | 1 | System takes the held word |
| tx_data | input | 16 | Word to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Word taken this cycle |
| overrun | output | 1 | Receive word dropped (pulse) |
| underrun | output | 1 | Transmit word missing (pulse) |

## Verification
The assertions assume that the configuration inputs change only while `cfg_en` is low. They also assume that `sync1_in` is already synchronous to the port clock and that the line length and line count are at least one. The stimulus changes configuration only after a disabled cycle, and it draws line lengths, delays and word counts from ranges that respect these limits. The pin sync, pin data and handshake inputs are randomized on every cycle, and occasional enable drops happen with the configuration held steady.

// File: rtl/ppfs_pkg.sv
package ppfs_pkg;
    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_WAIT = 2'd1,
        WIN_MOVE = 2'd2
    } win_state_e;
endpackage

// File: rtl/ppfs_syncgen.sv
module ppfs_syncgen #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          two_sync,
    input  logic [CW-1:0] line_len,
    input  logic [CW-1:0] lines,
    output logic          sync1,
    output logic          sync2
);
    logic [CW-1:0] pos;
    logic [CW-1:0] line;
    logic          pos_wrap;

    assign pos_wrap = (pos == line_len - 1'b1) || (line_len == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos  <= '0;
            line <= '0;
        end else if (!run) begin
            pos  <= '0;
            line <= '0;
        end else if (pos_wrap) begin
            pos <= '0;
            if ((line == lines - 1'b1) || (lines == '0)) line <= '0;
            else                                         line <= line + 1'b1;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    assign sync1 = run && (pos == '0);
    assign sync2 = run && two_sync && (pos == '0) && (line == '0);

    // R2
    sync1_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync1 && line_len > 1) |=> !sync1);
    // R3
    sync2_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync2 |-> sync1);
endmodule

// File: rtl/ppfs_window.sv
module ppfs_window
    import ppfs_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          trig,
    input  logic [CW-1:0] delay,
    input  logic [CW-1:0] words,
    output logic          xfer
);
    win_state_e    st, st_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= WIN_IDLE;
            cnt <= '0;
        end else if (!en) begin
            st  <= WIN_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            WIN_IDLE: begin
                if (trig && words != '0) begin
                    if (delay != '0) begin
                        st_nxt  = WIN_WAIT;
                        cnt_nxt = {{(CW-1){1'b0}}, 1'b1};
                    end else if (words != {{(CW-1){1'b0}}, 1'b1}) begin
                        st_nxt  = WIN_MOVE;
                        cnt_nxt = {{(CW-1){1'b0}}, 1'b1};
                    end
                end
            end
            WIN_WAIT: begin
                if (cnt == delay) begin
                    if (words == {{(CW-1){1'b0}}, 1'b1}) begin
                        st_nxt  = WIN_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        st_nxt  = WIN_MOVE;
                        cnt_nxt = {{(CW-1){1'b0}}, 1'b1};
                    end
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            WIN_MOVE: begin
                if (cnt == words - 1'b1) begin
                    st_nxt  = WIN_IDLE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                st_nxt  = WIN_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    always_comb begin
        xfer = 1'b0;
        if (en) begin
            unique case (st)
                WIN_IDLE: xfer = trig && (words != '0) && (delay == '0);
                WIN_WAIT: xfer = (cnt == delay);
                WIN_MOVE: xfer = 1'b1;
                default:  xfer = 1'b0;
            endcase
        end
    end

    // R1
    win_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == WIN_IDLE));
endmodule

// File: rtl/ppfs_lane.sv
module ppfs_lane #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dir_tx,
    input  logic          xfer,
    input  logic [DW-1:0] pd_in,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    input  logic          rx_ready,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          overrun,
    output logic          underrun,
    output logic [DW-1:0] pd_out,
    output logic          tx_ready
);
    logic rx_move;
    logic tx_move;

    assign rx_move  = en && xfer && !dir_tx;
    assign tx_move  = en && xfer && dir_tx;
    assign tx_ready = tx_move;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            overrun <= 1'b0;
            if (!en) begin
                rx_valid <= 1'b0;
            end else if (rx_move) begin
                if (rx_valid && !rx_ready) begin
                    overrun <= 1'b1;
                end else begin
                    rx_valid <= 1'b1;
                    rx_data  <= pd_in;
                end
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_out   <= '0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (tx_move) begin
                if (tx_valid) pd_out   <= tx_data;
                else          underrun <= 1'b1;
            end
        end
    end

    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (rx_valid && $stable(rx_data)));
    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && en) |=> (rx_valid && $stable(rx_data)));
    // R9
    unr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $stable(pd_out));
endmodule

// File: rtl/ppfs_ctrl.sv
module ppfs_ctrl #(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic          cfg_tx,
    input  logic          cfg_ext,
    input  logic          cfg_two_sync,
    input  logic [CW-1:0] cfg_line_len,
    input  logic [CW-1:0] cfg_lines,
    input  logic [CW-1:0] cfg_delay,
    input  logic [CW-1:0] cfg_words,
    input  logic          sync1_in,
    output logic          sync1_out,
    output logic          sync2_out,
    input  logic [DW-1:0] pd_in,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_ready,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic          overrun,
    output logic          underrun
);
    logic sync_q;
    logic ext_edge;
    logic int_run;
    logic trig;
    logic xfer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync1_in;
    end

    assign ext_edge = sync1_in && !sync_q;
    assign int_run  = cfg_en && !cfg_ext;
    assign trig     = cfg_en && (cfg_ext ? ext_edge : sync1_out);
    assign pd_oe    = cfg_en && cfg_tx;

    ppfs_syncgen #(.CW(CW)) i_syncgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (int_run),
        .two_sync (cfg_two_sync),
        .line_len (cfg_line_len),
        .lines    (cfg_lines),
        .sync1    (sync1_out),
        .sync2    (sync2_out)
    );

    ppfs_window #(.CW(CW)) i_window (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_en),
        .trig  (trig),
        .delay (cfg_delay),
        .words (cfg_words),
        .xfer  (xfer)
    );

    ppfs_lane #(.DW(DW)) i_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .dir_tx   (cfg_tx),
        .xfer     (xfer),
        .pd_in    (pd_in),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .overrun  (overrun),
        .underrun (underrun),
        .pd_out   (pd_out),
        .tx_ready (tx_ready)
    );

    // R4
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ext |-> (!sync1_out && !sync2_out));
endmodule

// File: tb/test_ppfs_ctrl.sv
module test_ppfs_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_tx = 1'b0, cfg_ext = 1'b0, cfg_two_sync = 1'b0;
    logic [15:0] cfg_line_len = 16'd8, cfg_lines = 16'd2, cfg_delay = '0, cfg_words = 16'd1;
    logic        sync1_in = 1'b0;
    logic [15:0] pd_in = '0, tx_data = '0;
    logic        rx_ready = 1'b0, tx_valid = 1'b0;
    logic        sync1_out, sync2_out, pd_oe, rx_valid, tx_ready, overrun, underrun;
    logic [15:0] pd_out, rx_data;

    int checks = 0;
    int errors = 0;

    // bench model state
    int          n = 0;
    bit          busy = 0;
    int          k = 0;
    bit          prev_s = 0;
    bit          rv = 0;
    logic [15:0] rd = '0;
    logic [15:0] epd = '0;
    bit          e_ovr = 0, e_unr = 0;

    always #4 clk = ~clk;

    ppfs_ctrl i_ppfs_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_tx(cfg_tx), .cfg_ext(cfg_ext),
        .cfg_two_sync(cfg_two_sync), .cfg_line_len(cfg_line_len), .cfg_lines(cfg_lines),
        .cfg_delay(cfg_delay), .cfg_words(cfg_words), .sync1_in(sync1_in),
        .sync1_out(sync1_out), .sync2_out(sync2_out), .pd_in(pd_in), .pd_out(pd_out),
        .pd_oe(pd_oe), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .overrun(overrun), .underrun(underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit line_sync(input int cyc, input int len);
        return (cyc % len) == 0;
    endfunction

    function automatic bit frame_sync(input int cyc, input int len, input int nl);
        return (cyc % (len * nl)) == 0;
    endfunction

    // one port clock: inputs already driven after a falling edge
    task automatic step();
        bit trig, xf, s1;
        #1;
        s1   = cfg_en && !cfg_ext && line_sync(n, int'(cfg_line_len));
        trig = cfg_en && (cfg_ext ? (sync1_in && !prev_s) : s1);
        if (!cfg_en) begin
            busy = 0; xf = 0;
        end else begin
            if (!busy && trig && cfg_words != 0) begin busy = 1; k = 0; end
            xf = busy && (k >= int'(cfg_delay));
            if (busy) begin
                if (k == int'(cfg_delay) + int'(cfg_words) - 1) busy = 0;
                else k++;
            end
        end
        if (!cfg_en)      chk("R1 sync1", 32'(sync1_out), 32'd0);
        else if (cfg_ext) chk("R4 sync1", 32'(sync1_out), 32'd0);
        else              chk("R2 sync1", 32'(sync1_out), 32'(s1));
        if (cfg_ext) chk("R4 sync2", 32'(sync2_out), 32'd0);
        else chk("R3 sync2", 32'(sync2_out),
                 32'(s1 && cfg_two_sync && frame_sync(n, int'(cfg_line_len), int'(cfg_lines))));
        if (cfg_tx) chk("R5 window timing", 32'(tx_ready), 32'(xf));
        else        chk("R5 no ready in rx", 32'(tx_ready), 32'd0);
        chk("R8 pd_oe", 32'(pd_oe), 32'(cfg_en && cfg_tx));
        e_ovr = 0; e_unr = 0;
        if (!cfg_en) rv = 0;
        else if (xf && !cfg_tx) begin
            if (rv && !rx_ready) e_ovr = 1;
            else begin rv = 1; rd = pd_in; end
        end else if (rx_ready) rv = 0;
        if (cfg_en && xf && cfg_tx) begin
            if (tx_valid) epd = tx_data;
            else e_unr = 1;
        end
        prev_s = sync1_in;
        n = cfg_en ? n + 1 : 0;
        @(posedge clk);
        @(negedge clk);
        chk("R6 rx_valid", 32'(rx_valid), 32'(rv));
        if (rv) chk("R6 rx_data", 32'(rx_data), 32'(rd));
        chk("R7 overrun", 32'(overrun), 32'(e_ovr));
        chk("R9 underrun", 32'(underrun), 32'(e_unr));
        chk("R8 pd_out", 32'(pd_out), 32'(epd));
    endtask

    task automatic drive(input int p_sync, input int p_ready, input int p_valid);
        sync1_in = ($urandom % 100) < p_sync;
        rx_ready = ($urandom % 100) < p_ready;
        tx_valid = ($urandom % 100) < p_valid;
        pd_in    = 16'($urandom);
        tx_data  = 16'($urandom);
    endtask

    task automatic scenario(input bit tx, input bit ext, input bit two, input int len,
                            input int nl, input int dly, input int w, input int cyc,
                            input int p_sync, input int p_ready, input int p_valid,
                            input int p_drop);
        cfg_en = 0;
        drive(0, p_ready, p_valid);
        step();
        cfg_tx = tx; cfg_ext = ext; cfg_two_sync = two;
        cfg_line_len = 16'(len); cfg_lines = 16'(nl);
        cfg_delay = 16'(dly); cfg_words = 16'(w);
        for (int c = 0; c < cyc; c++) begin
            cfg_en = ($urandom % 100) >= p_drop;
            drive(p_sync, p_ready, p_valid);
            step();
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset sync1", 32'(sync1_out), 32'd0);
        chk("R1 reset rx_valid", 32'(rx_valid), 32'd0);
        chk("R1 reset pd_out", 32'(pd_out), 32'd0);
        chk("R1 reset pd_oe", 32'(pd_oe), 32'd0);
        // directed corners
        scenario(0, 0, 0, 8, 3, 0, 4, 60, 0, 70, 0, 0);     // R5 zero delay receive
        scenario(1, 0, 1, 10, 3, 3, 5, 90, 0, 0, 80, 0);    // R3 two levels, transmit
        scenario(0, 1, 0, 8, 1, 2, 3, 120, 25, 0, 0, 0);    // R7 overrun, rx never ready
        scenario(1, 1, 0, 8, 1, 0, 1, 80, 30, 0, 50, 0);    // R4 single word, zero delay
        scenario(0, 0, 1, 6, 2, 1, 0, 40, 0, 50, 0, 0);     // R5 zero words
        scenario(1, 1, 1, 8, 1, 5, 2, 100, 20, 0, 0, 0);    // R9 always underrun
        scenario(0, 0, 1, 5, 4, 1, 3, 100, 0, 60, 0, 5);    // R1 enable drops
        scenario(1, 0, 0, 1, 1, 0, 1, 30, 0, 0, 60, 0);     // R2 line length one
        // random configurations
        for (int r = 0; r < 24; r++) begin
            int len, dly, w;
            len = 3 + int'($urandom % 12);
            dly = int'($urandom % (len / 2 + 1));
            w   = int'($urandom % (len - dly + 1));
            scenario(1'($urandom), 1'($urandom), 1'($urandom), len,
                     1 + int'($urandom % 4), dly, w, 150,
                     20, 60, 70, int'($urandom % 4));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule